// File: doc/BRIEF.md
# Burst Column Address Generator

This block sits beside the command sequencer of a synchronous DRAM controller and produces the column address for each data beat of a read or write burst. On a start pulse it takes a mode word and a starting column. The burst-length field and the ordering bit decide how the beats are ordered. After that it presents one column per clock while the advance enable is high. The block also flags the final beat of a burst.

A burst runs for 1, 2, 4 or 8 beats, or for a whole 512-column page. Fixed-length bursts wrap inside the block of columns aligned to their length. The ordering inside that block is either counting upward or the start offset XORed with the beat number. A stop input ends a burst early. A fresh start pulse cuts the current burst off and begins a new one. The block also reports whether the latency field of the same mode word holds a supported value.

Top module: `burst_col_gen`

## Requirements
- R1: After a synchronous reset, `beat_valid`, `last_beat` and `len_err` are low.
- R2: `mode_word[2:0]` sets the burst length: 000 gives 1 beat, 001 gives 2, 010 gives 4 and 011 gives 8. `last_beat` is high on the final beat only.
- R3: When `mode_word[3]` is 0 (sequential), beat k of an L-beat burst is the start column with its low log2(L) bits replaced by (start offset + k) mod L. The upper bits are kept.
- R4: When `mode_word[3]` is 1 (interleaved), beat k is the start column with its low log2(L) bits XORed with k. The upper bits are kept.
- R5: Code 111 selects page mode. Beat k is (start + k) mod 512, the ordering bit is ignored, and `last_beat` is never raised. The burst runs until it is stopped or restarted.
- R6: Codes 100, 101 and 110 are reserved. They raise `len_err` for the whole burst, and the burst is a single beat at the start column.
- R7: `lat_bad` is high, combinationally, whenever `mode_word[6:4]` is neither 010 nor 011.
- R8: While `adv_en` is low, with no start and no stop, the current beat and its column are held.
- R9: `stop` without `start` ends the burst, so `beat_valid` is low on the next cycle.
- R10: `start` takes priority over `stop` and `adv_en`. On the next cycle the burst is restarted at beat 0, using the new mode word and `col_in`.
- R11: When the last beat is consumed (`last_beat` and `adv_en` high), `beat_valid` is low on the next cycle unless a start arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_word | input | 12 | Mode word; length [2:0], ordering [3], latency [6:4] |
| start | input | 1 | Begin a new burst (sampled with mode_word and col_in) |
| col_in | input | 9 | Starting column of the burst |
| adv_en | input | 1 | Consume the current beat and move to the next |
| stop | input | 1 | End the burst early |
| col_out | output | 9 | Column of the current beat |
| beat_valid | output | 1 | A beat is being presented |
| last_beat | output | 1 | Current beat is the final one of the burst |
| len_err | output | 1 | Current burst was started with a reserved length code |
| lat_bad | output | 1 | Latency field of mode_word is unsupported |

## Verification
The assertions assume three things about the inputs. First, `mode_word` and `col_in` matter only in the cycle where `start` is high. Second, `start` outranks `stop`, which outranks `adv_en`. Third, `adv_en` may be high while no burst is active, and is then ignored. The stimulus drives every length code under both orderings and several start columns, including ones near the top of the page. It also covers gapped advance patterns, a stop part-way through, and a restart issued together with stop and advance. All inputs change well away from the sampling edge, so the per-cycle reference model always sees the same values as the design.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

    typedef enum logic [2:0] {
        BL_ONE  = 3'b000,
        BL_TWO  = 3'b001,
        BL_FOUR = 3'b010,
        BL_EIGHT= 3'b011,
        BL_PAGE = 3'b111
    } bl_code_e;

    typedef struct packed {
        logic [1:0] len_log;   // log2 of beats for fixed bursts
        logic       page;      // whole-page burst
        logic       ilv;       // interleaved ordering
        logic       bad;       // reserved length code
    } burst_cfg_t;

    function automatic burst_cfg_t decode_cfg(input logic [2:0] lcode, input logic tbit);
        burst_cfg_t c;
        c.len_log = 2'd0;
        c.page    = 1'b0;
        c.ilv     = tbit;
        c.bad     = 1'b0;
        case (lcode)
            BL_ONE:   c.len_log = 2'd0;
            BL_TWO:   c.len_log = 2'd1;
            BL_FOUR:  c.len_log = 2'd2;
            BL_EIGHT: c.len_log = 2'd3;
            BL_PAGE:  c.page    = 1'b1;
            default:  c.bad     = 1'b1;
        endcase
        return c;
    endfunction

    function automatic logic lat_supported(input logic [2:0] f);
        return (f == 3'd2) || (f == 3'd3);
    endfunction

endpackage

// File: rtl/bcg_mode_dec.sv
module bcg_mode_dec
    import bcg_pkg::*;
#(
    parameter int MODE_W = 12
) (
    input  logic [MODE_W-1:0] mode_word,
    output burst_cfg_t        cfg,
    output logic              lat_bad
);
    localparam int LEN_LSB = 0;
    localparam int TYP_BIT = 3;
    localparam int LAT_LSB = 4;

    always_comb begin
        cfg     = decode_cfg(mode_word[LEN_LSB +: 3], mode_word[TYP_BIT]);
        lat_bad = !lat_supported(mode_word[LAT_LSB +: 3]);
    end
endmodule

// File: rtl/bcg_beat_ctr.sv
module bcg_beat_ctr
    import bcg_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             stop,
    input  logic             adv,
    input  burst_cfg_t       cfg_in,
    output logic             active,
    output logic [COL_W-1:0] idx,
    output burst_cfg_t       cfg_q,
    output logic             last
);
    logic [COL_W-1:0] lim;

    always_comb begin
        lim  = (COL_W'(1) << cfg_q.len_log) - COL_W'(1);
        last = active && !cfg_q.page && (idx == lim);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            idx    <= '0;
            cfg_q  <= '0;
        end else if (start) begin
            active <= 1'b1;
            idx    <= '0;
            cfg_q  <= cfg_in;
        end else if (stop) begin
            active <= 1'b0;
        end else if (active && adv) begin
            if (last) active <= 1'b0;
            else      idx    <= idx + COL_W'(1);
        end
    end

    // R10
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> (active && idx == '0));
    // R9
    stop_end_chk: assert property (@(posedge clk) disable iff (rst)
        (stop && !start) |=> !active);
    // R8
    hold_beat_chk: assert property (@(posedge clk) disable iff (rst)
        (active && !adv && !start && !stop) |=> (active && $stable(idx)));
    // R11
    last_end_chk: assert property (@(posedge clk) disable iff (rst)
        (last && adv && !start && !stop) |=> !active);
endmodule

// File: rtl/bcg_addr_map.sv
module bcg_addr_map
    import bcg_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] idx,
    input  burst_cfg_t       cfg,
    output logic [COL_W-1:0] col
);
    logic [COL_W-1:0] sum;
    logic [COL_W-1:0] mix;

    assign sum = base + idx;
    assign mix = base ^ idx;

    for (genvar b = 0; b < COL_W; b++) begin : g_bit
        always_comb begin
            if (cfg.page)
                col[b] = sum[b];
            else if (int'(cfg.len_log) > b)
                col[b] = cfg.ilv ? mix[b] : sum[b];
            else
                col[b] = base[b];
        end
    end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
    import bcg_pkg::*;
#(
    parameter int MODE_W = 12,
    parameter int COL_W  = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] mode_word,
    input  logic              start,
    input  logic [COL_W-1:0]  col_in,
    input  logic              adv_en,
    input  logic              stop,
    output logic [COL_W-1:0]  col_out,
    output logic              beat_valid,
    output logic              last_beat,
    output logic              len_err,
    output logic              lat_bad
);
    burst_cfg_t       cfg_dec;
    burst_cfg_t       cfg_q;
    logic             active;
    logic             last;
    logic [COL_W-1:0] idx;
    logic [COL_W-1:0] base_q;

    bcg_mode_dec #(.MODE_W(MODE_W)) u_dec (
        .mode_word (mode_word),
        .cfg       (cfg_dec),
        .lat_bad   (lat_bad)
    );

    bcg_beat_ctr #(.COL_W(COL_W)) u_ctr (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .stop   (stop),
        .adv    (adv_en),
        .cfg_in (cfg_dec),
        .active (active),
        .idx    (idx),
        .cfg_q  (cfg_q),
        .last   (last)
    );

    always_ff @(posedge clk) begin
        if (rst)        base_q <= '0;
        else if (start) base_q <= col_in;
    end

    bcg_addr_map #(.COL_W(COL_W)) u_map (
        .base (base_q),
        .idx  (idx),
        .cfg  (cfg_q),
        .col  (col_out)
    );

    assign beat_valid = active;
    assign last_beat  = last;
    assign len_err    = active && cfg_q.bad;

    // R5
    page_step_chk: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && cfg_q.page && adv_en && !start && !stop)
        |=> (col_out == $past(col_out) + COL_W'(1)) && !last_beat);
    // R4 (upper column bits also stay fixed for R3)
    upper_fixed_chk: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && !cfg_q.page) |-> (((col_out ^ base_q) >> cfg_q.len_log) == '0));
    // R6
    bad_single_chk: assert property (@(posedge clk) disable iff (rst)
        len_err |-> (last_beat && col_out == base_q));
    // R2
    last_valid_chk: assert property (@(posedge clk) disable iff (rst)
        last_beat |-> beat_valid);
endmodule

// File: tb/burst_col_gen_tb.sv
`timescale 1ns/1ps
module burst_col_gen_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] mode_word = '0;
    logic        start = 1'b0;
    logic [8:0]  col_in = '0;
    logic        adv_en = 1'b0;
    logic        stop = 1'b0;
    logic [8:0]  col_out;
    logic        beat_valid, last_beat, len_err, lat_bad;

    int tests = 0;
    int fails = 0;
    bit done = 0;
    string cur_req = "R2";

    always #10 clk = ~clk;

    burst_col_gen u_dut (
        .clk(clk), .rst(rst), .mode_word(mode_word), .start(start),
        .col_in(col_in), .adv_en(adv_en), .stop(stop), .col_out(col_out),
        .beat_valid(beat_valid), .last_beat(last_beat), .len_err(len_err),
        .lat_bad(lat_bad)
    );

    // behavioural reference
    int q[$];
    bit m_act = 0, m_page = 0, m_bad = 0;
    int m_base = 0, m_k = 0, m_len = 0, m_off = 0, m_blk = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_act = 0; m_bad = 0; m_page = 0; q.delete();
        end else if (start) begin
            m_bad = 0; m_page = 0;
            case (int'(mode_word[2:0]))
                0: m_len = 1;
                1: m_len = 2;
                2: m_len = 4;
                3: m_len = 8;
                7: begin m_len = 0; m_page = 1; end
                default: begin m_len = 1; m_bad = 1; end
            endcase
            m_base = int'(col_in); m_k = 0; q.delete();
            if (!m_page) begin
                m_off = m_base % m_len;
                m_blk = m_base - m_off;
                for (int k = 0; k < m_len; k++) begin
                    if (mode_word[3]) q.push_back(m_blk + (m_off ^ k));
                    else              q.push_back(m_blk + (m_off + k) % m_len);
                end
            end
            m_act = 1;
        end else if (stop) begin
            m_act = 0;
        end else if (m_act && adv_en) begin
            if (m_page) m_k++;
            else begin
                void'(q.pop_front());
                if (q.size() == 0) m_act = 0;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            int  ecol;
            bit  elast, eerr, bad;
            ecol  = m_page ? (m_base + m_k) % 512 : (q.size() > 0 ? q[0] : 0);
            elast = m_act && !m_page && q.size() == 1;
            eerr  = m_act && m_bad;
            bad   = (beat_valid !== m_act) || (last_beat !== elast) || (len_err !== eerr)
                    || (m_act && int'(col_out) != ecol);
            tests++;
            if (bad) begin
                fails++;
                $display("FAIL %s: valid=%0b/%0b last=%0b/%0b err=%0b/%0b col=%0h/%0h (actual/expected)",
                         cur_req, beat_valid, m_act, last_beat, elast, len_err, eerr, col_out, ecol);
            end
        end
    end

    function automatic logic [11:0] mk(input logic [2:0] len, input logic ty);
        return {5'd0, 3'd2, ty, len};
    endfunction

    task automatic step(input logic s, input logic [11:0] m, input logic [8:0] c,
                        input logic a, input logic p);
        @(posedge clk); #2;
        start = s; mode_word = m; col_in = c; adv_en = a; stop = p;
    endtask

    task automatic burst(input logic [11:0] m, input logic [8:0] c);
        step(1, m, c, 0, 0);
        repeat (10) step(0, m, 9'h0, 1, 0);
        step(0, m, 9'h0, 0, 0);
    endtask

    task automatic finish_up;
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete (actual hung, expected finish)");
        finish_up();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        // R1: outputs idle right after reset
        @(negedge clk);
        tests++;
        if (beat_valid !== 1'b0 || last_beat !== 1'b0 || len_err !== 1'b0) begin
            fails++;
            $display("FAIL R1: valid=%0b last=%0b err=%0b expected 0 0 0", beat_valid, last_beat, len_err);
        end

        // R7: latency field decode
        for (int v = 0; v < 8; v++) begin
            step(0, {5'd0, 3'(v), 4'd0}, 9'h0, 0, 0);
            #1;
            tests++;
            if (lat_bad !== ((v != 2) && (v != 3))) begin
                fails++;
                $display("FAIL R7: lat field %0d lat_bad=%0b expected %0b", v, lat_bad, (v != 2) && (v != 3));
            end
        end

        // R2 R3 R4 R11: every fixed length, both orders, several columns
        for (int t = 0; t < 2; t++) begin
            for (int l = 0; l < 4; l++) begin
                cur_req = (t == 0) ? "R3" : "R4";
                burst(mk(3'(l), 1'(t)), 9'h1A5);
                burst(mk(3'(l), 1'(t)), 9'h0F3);
                burst(mk(3'(l), 1'(t)), 9'h1FF);
                cur_req = "R2";
                burst(mk(3'(l), 1'(t)), 9'h008);
            end
        end
        cur_req = "R11";
        burst(mk(3'd2, 1'b0), 9'h002);

        // R8: gapped advance holds beat
        cur_req = "R8";
        step(1, mk(3'd3, 1'b1), 9'h00D, 0, 0);
        for (int i = 0; i < 18; i++) step(0, 12'h0, 9'h0, 1'(i % 3 == 2), 0);
        step(0, 12'h0, 9'h0, 0, 0);

        // R5: page mode wraps over top of page, ordering bit ignored
        cur_req = "R5";
        step(1, mk(3'd7, 1'b1), 9'h1FC, 0, 0);
        repeat (20) step(0, 12'h0, 9'h0, 1, 0);
        step(0, 12'h0, 9'h0, 0, 0);
        cur_req = "R9";
        step(0, 12'h0, 9'h0, 1, 1);
        step(0, 12'h0, 9'h0, 0, 0);
        step(0, 12'h0, 9'h0, 0, 0);

        // R6: reserved length codes
        cur_req = "R6";
        burst(mk(3'd4, 1'b0), 9'h077);
        burst(mk(3'd5, 1'b1), 9'h077);
        burst(mk(3'd6, 1'b0), 9'h1E1);

        // R9: stop part-way through an 8-beat burst
        cur_req = "R9";
        step(1, mk(3'd3, 1'b0), 9'h0C4, 0, 0);
        repeat (3) step(0, 12'h0, 9'h0, 1, 0);
        step(0, 12'h0, 9'h0, 1, 1);
        repeat (3) step(0, 12'h0, 9'h0, 1, 0);

        // R10: restart with stop and advance asserted together
        cur_req = "R10";
        step(1, mk(3'd3, 1'b0), 9'h010, 0, 0);
        repeat (2) step(0, 12'h0, 9'h0, 1, 0);
        step(1, mk(3'd2, 1'b1), 9'h1A6, 1, 1);
        repeat (6) step(0, 12'h0, 9'h0, 1, 0);
        step(1, mk(3'd7, 1'b0), 9'h0FE, 1, 0);
        repeat (4) step(0, 12'h0, 9'h0, 1, 0);
        step(1, mk(3'd1, 1'b0), 9'h033, 0, 0);
        repeat (4) step(0, 12'h0, 9'h0, 1, 0);

        @(negedge clk);
        #1 finish_up();
    end
endmodule